// File: doc/BRIEF.md
# RS-485 Bus Polarity Correction Controller

This block is the digital side of a half-duplex RS-485 node that can be wired to the bus with its A and B lines swapped. It takes the decision of the receive comparator, the driver enable, the active-low receiver enable and the transmit data bit. It returns the receive data with an enable and a valid flag, the data and enable for the line driver, and a flag that shows whether the node runs inverted.

While the node only listens, the failsafe bias network should hold the bus at a valid high. If the comparator instead reports a steady valid low for a full failsafe window, the wires must be crossed. A cycle counter measures that window. When it expires, a pending bit is set. That bit is committed to the inversion flag on the next low-to-high edge of the receiver enable. From then on, the flag inverts both the receive data and the transmit data until the next reset. Reset stands in for power-up, so the polarity is worked out again each time the node starts.

High-impedance and undefined outputs are not tri-state nets. They are carried as explicit enable and valid signals, so the block stays plain synchronous logic.

Top module: `polfix_ctrl`

## Requirements
- R1: The idle timer advances only in a cycle where `drv_en` is 0, `rx_en_n` is 0 and `cmp_state` is 2'b10 (valid low). Any other cycle returns the timer to zero. Comparator encoding: 2'b01 is valid high, 2'b10 is valid low, and 2'b00 and 2'b11 are indeterminate.
- R2: After exactly FS_CYCLES consecutive qualifying cycles, a pending-correction bit is set. The bit stays set if the bus later leaves idle, until it is committed. With FS_CYCLES-1 qualifying cycles, nothing is pending.
- R3: The pending bit becomes the inversion flag `pol_inv` on a clock edge where `rx_en_n` is 1 and was 0 on the edge before. `pol_inv` is 1 one clock after that edge is sampled. Before the commit, the data paths stay uninverted.
- R4: Once set, `pol_inv` holds through all later traffic and enable changes. Only reset clears it. Reset also clears the timer and the pending bit.
- R5: `rx_oe` equals the inverse of `rx_en_n`. With `rx_oe` at 1, `rx_valid` is 1 exactly when `cmp_state` is valid high or valid low, and `rx_data` is (cmp_state == 2'b01) XOR `pol_inv`. With `rx_valid` at 0, `rx_data` is 0.
- R6: When `pol_inv` is 0 and `drv_en` is 1: `bus_oe` is 1 and `bus_drive` equals `tx_data`. If `tx_open` is 1, `bus_drive` is 1.
- R7: When `pol_inv` is 1 and `drv_en` is 1: `bus_drive` is the inverse of `tx_data`. If `tx_open` is 1, `bus_drive` is 0.
- R8: When `drv_en` is 0, `bus_oe` is 0 and `bus_drive` is 0 in either polarity.
- R9: When `rx_en_n` is 1, `rx_oe`, `rx_valid` and `rx_data` are all 0 in either polarity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset (power-up) |
| cmp_state | input | 2 | Comparator decision: 01 high, 10 low, 00/11 indeterminate |
| drv_en | input | 1 | Driver enable |
| rx_en_n | input | 1 | Active-low receiver enable |
| tx_data | input | 1 | Transmit data bit |
| tx_open | input | 1 | Transmit data input left unconnected |
| bus_drive | output | 1 | Data level sent to the line driver |
| bus_oe | output | 1 | Line driver output enable |
| rx_data | output | 1 | Receive data |
| rx_oe | output | 1 | Receive output enable |
| rx_valid | output | 1 | Receive data is defined |
| pol_inv | output | 1 | Latched polarity inversion flag |

## Verification
A vector table runs through every combination class of driver enable, open data, receiver enable and comparator state. It is applied once in normal polarity and once in corrected polarity. Comparing the two passes separates the plain data paths from the inverted ones, and shows that the disabled and undefined cases stay polarity-independent. Directed idle sequences then test the detection timer. One run is one cycle short of expiry. Others are broken by a driver enable pulse or an indeterminate comparator cycle, and one expires exactly on time. Together they separate a correct restart and an exact count from an off-by-one or a missing restart. A final test resets the block with the timer partly loaded and continues the idle run, which shows whether reset truly clears the timer.

// File: rtl/polfix_ctrl.sv
module polfix_ctrl #(
  parameter int FS_CYCLES = 3_800_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] cmp_state,
  input  logic       drv_en,
  input  logic       rx_en_n,
  input  logic       tx_data,
  input  logic       tx_open,
  output logic       bus_drive,
  output logic       bus_oe,
  output logic       rx_data,
  output logic       rx_oe,
  output logic       rx_valid,
  output logic       pol_inv
);
  localparam int CW = $clog2(FS_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(FS_CYCLES - 1);
  localparam logic [1:0] CMP_HI = 2'b01;
  localparam logic [1:0] CMP_LO = 2'b10;

  logic [CW-1:0] idle_cnt;
  logic          pend;
  logic          re_q;
  logic          qual;
  logic          re_rise;

  assign qual    = !drv_en && !rx_en_n && (cmp_state == CMP_LO);
  assign re_rise = rx_en_n && !re_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_cnt <= '0;
      pend     <= 1'b0;
      pol_inv  <= 1'b0;
      re_q     <= 1'b1;
    end else begin
      re_q <= rx_en_n;
      if (qual) begin
        if (idle_cnt == LAST) pend <= 1'b1;
        else idle_cnt <= idle_cnt + 1'b1;
      end else begin
        idle_cnt <= '0;
      end
      if (re_rise) begin
        if (pend) pol_inv <= 1'b1;
        pend <= 1'b0;
      end
    end
  end

  assign rx_oe     = !rx_en_n;
  assign rx_valid  = rx_oe && ((cmp_state == CMP_HI) || (cmp_state == CMP_LO));
  assign rx_data   = rx_valid && ((cmp_state == CMP_HI) ^ pol_inv);
  assign bus_oe    = drv_en;
  assign bus_drive = drv_en && (tx_open ? !pol_inv : (tx_data ^ pol_inv));

  a_r2_pend_after_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend) |-> $past(!drv_en && !rx_en_n && cmp_state == CMP_LO));

  a_r3_commit_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pol_inv) |-> $past(rx_en_n && !re_q && pend));

  a_r4_flag_held: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(pol_inv));

  a_r8_driver_off: assert property (@(posedge clk) disable iff (!rst_n)
    !drv_en |-> (!bus_oe && !bus_drive));

  a_r9_rx_off: assert property (@(posedge clk) disable iff (!rst_n)
    rx_en_n |-> (!rx_oe && !rx_valid && !rx_data));
endmodule

// File: tb/polfix_ctrl_tb.sv
`timescale 1ns/1ps
module polfix_ctrl_tb_top;
  localparam int FS = 20;
  localparam int NV = 8;
  // {drv_en, tx_data, tx_open, rx_en_n, cmp[1:0], bus_oe, bus_drive, rx_oe, rx_valid, rx_data} for normal polarity
  localparam logic [10:0] VEC [NV] = '{
    11'b1_1_0_0_01_1_1_1_1_1,
    11'b1_0_0_0_10_1_0_1_1_0,
    11'b1_0_1_1_01_1_1_0_0_0,
    11'b0_1_0_0_00_0_0_1_0_0,
    11'b0_0_0_1_10_0_0_0_0_0,
    11'b0_1_1_0_11_0_0_1_0_0,
    11'b1_1_1_0_10_1_1_1_1_0,
    11'b0_0_0_0_01_0_0_1_1_1
  };

  logic clk = 0, rst_n = 0;
  logic [1:0] cmp_state = 2'b01;
  logic drv_en = 0, rx_en_n = 1, tx_data = 0, tx_open = 0;
  logic bus_drive, bus_oe, rx_data, rx_oe, rx_valid, pol_inv;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  polfix_ctrl #(.FS_CYCLES(FS)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmp_state(cmp_state), .drv_en(drv_en),
    .rx_en_n(rx_en_n), .tx_data(tx_data), .tx_open(tx_open),
    .bus_drive(bus_drive), .bus_oe(bus_oe), .rx_data(rx_data),
    .rx_oe(rx_oe), .rx_valid(rx_valid), .pol_inv(pol_inv));

  task automatic check(string tag, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic idle(int n);
    @(negedge clk);
    drv_en = 0; rx_en_n = 0; cmp_state = 2'b10;
    repeat (n) @(negedge clk);
  endtask

  task automatic re_rise();
    rx_en_n = 1;
    @(negedge clk);
  endtask

  task automatic walk(logic inv);
    for (int i = 0; i < NV; i++) begin
      logic [10:0] v;
      logic e_drv, e_rd;
      v = VEC[i];
      @(negedge clk);
      {drv_en, tx_data, tx_open, rx_en_n, cmp_state} = v[10:5];
      #1;
      e_drv = v[3];
      e_rd  = v[0];
      if (inv) begin
        if (v[4]) e_drv = v[8] ? 1'b0 : !v[9];
        if (v[1]) e_rd = !v[0];
      end
      check(inv ? "R8 corr bus_oe" : "R8 norm bus_oe", bus_oe, v[4]);
      check(inv ? "R7 corr bus_drive" : "R6 norm bus_drive", bus_drive, e_drv);
      check("R9 rx_oe", rx_oe, v[2]);
      check("R5 rx_valid", rx_valid, v[1]);
      check(inv ? "R5 corr rx_data" : "R5 norm rx_data", rx_data, e_rd);
    end
    @(negedge clk);
    rx_en_n = 1; drv_en = 0; cmp_state = 2'b01;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check("R4 reset pol_inv", pol_inv, 0);
    check("R9 reset rx_oe", rx_oe, 0);
    check("R8 reset bus_oe", bus_oe, 0);
    rst_n = 1;

    walk(0);

    idle(FS - 1);
    drv_en = 1;
    @(negedge clk);
    idle(FS - 1);
    re_rise();
    check("R1 drv_en restarts timer", pol_inv, 0);

    idle(10);
    cmp_state = 2'b00;
    @(negedge clk);
    idle(FS - 1);
    re_rise();
    check("R1 indeterminate restarts timer", pol_inv, 0);

    idle(FS - 1);
    re_rise();
    check("R2 one cycle short", pol_inv, 0);

    idle(FS);
    cmp_state = 2'b01;
    repeat (3) @(negedge clk);
    #1;
    check("R3 not applied before commit rx_data", rx_data, 1);
    check("R3 not applied before commit pol_inv", pol_inv, 0);
    @(negedge clk);
    rx_en_n = 1;
    #1;
    check("R3 flag one clock late", pol_inv, 0);
    @(negedge clk);
    #1;
    check("R2 sticky pending committed", pol_inv, 1);

    walk(1);

    for (int k = 0; k < 4; k++) begin
      @(negedge clk); rx_en_n = 0; drv_en = k[0]; cmp_state = 2'b01;
      @(negedge clk); rx_en_n = 1;
    end
    @(negedge clk);
    #1;
    check("R4 flag held", pol_inv, 1);

    idle(15);
    rst_n = 0;
    #1;
    check("R4 reset clears flag", pol_inv, 0);
    @(negedge clk);
    rst_n = 1;
    idle(5);
    re_rise();
    check("R4 reset clears timer", pol_inv, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule